// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-input interrupt controller. Each request line is captured into a request register. A per-input trigger selection decides whether a line is captured on its rising edge or followed by its level. A mask bus removes inputs from consideration. The remaining requests are ranked in a circular order whose starting point is a stored three-bit offset. The best candidate is then compared against the best input already in service, and the block raises its interrupt output only when the candidate ranks strictly ahead of it.

When the processor acknowledges, the block reports which input won and moves that input into service, or skips the in-service mark when automatic end-of-interrupt is enabled. It can also advance the rotation offset so that the acknowledged input drops to the lowest priority. When a master controller runs in special nested mode, it leaves the cascade input's in-service bit out of the current-priority calculation. This lets further requests from a downstream controller get through. Register access decoding and cascade wiring belong to the surrounding logic.

Top module: `rp_irq_core`

## Requirements
- R1: While `rst_n` is low, the request register, in-service register, previous-level copy and rotation offset are all zero, and `irq_out`, `ack_done`, `ack_hit` and `ack_idx` are zero.
- R2: For an input whose `trig_level` bit is 1, the request bit equals the line value sampled at the previous clock edge. An acknowledge does not clear it.
- R3: For an input whose `trig_level` bit is 0, the request bit is set at the edge after the line changes from 0 to 1, and it stays set while the line is low or held high. Only an acknowledge of that input clears it, and a rising line in the same cycle sets it again.
- R4: Rank k (0 = best, 0..7) belongs to input (k + offset) mod 8. The winner is the candidate with the lowest rank.
- R5: Candidates are the request bits whose `mask` bit is 0. A masked request stays latched but cannot win.
- R6: A winner is pending only when its rank is strictly lower than the lowest rank present in the in-service register. An empty set counts as rank 8.
- R7: When `nested_special` and `is_master` are both 1, in-service bit 2 (the cascade input) is ignored in the R6 comparison.
- R8: `irq_out` equals the pending flag of the state and inputs seen at the previous clock edge.
- R9: On an edge with `ack` = 1 and a pending winner, the next cycle shows `ack_done` = 1, `ack_hit` = 1 and `ack_idx` = winner. The winner's in-service bit is set when `auto_eoi` is 0.
- R10: When `auto_eoi` is 1, an acknowledge leaves the in-service register unchanged. When `rot_on_aeoi` is also 1, the offset becomes (winner + 1) mod 8. No other event changes the offset.
- R11: An `ack` with nothing pending gives `ack_done` = 1, `ack_hit` = 0 and `ack_idx` = 7 in the next cycle. The request and in-service registers are not changed by it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_in | input | 8 | Interrupt request lines |
| trig_level | input | 8 | Per input: 1 = level capture, 0 = rising-edge capture |
| mask | input | 8 | Per input: 1 = excluded from candidates |
| auto_eoi | input | 1 | Acknowledge does not mark the input as in service |
| rot_on_aeoi | input | 1 | With auto_eoi, rotate priority behind the acknowledged input |
| nested_special | input | 1 | Special nested mode enable |
| is_master | input | 1 | Block acts as the master of a cascade |
| ack | input | 1 | Interrupt acknowledge strobe |
| irq_out | output | 1 | Registered interrupt request |
| ack_done | output | 1 | Pulses the cycle after an acknowledge |
| ack_hit | output | 1 | The last acknowledge found a pending winner |
| ack_idx | output | 3 | Input returned by the last acknowledge (7 when spurious) |
| irr_out | output | 8 | Request register |
| isr_out | output | 8 | In-service register |

## Verification
A line change shows in `irr_out` one edge after it is driven. It reaches `irq_out` one edge later, because the resolver is combinational and only the output stage is registered. An acknowledge shows in `ack_done`, `ack_hit`, `ack_idx`, `isr_out` and the offset at the edge that samples it, and its effect on `irq_out` appears one edge after that. The bench drives inputs on the falling edge and steps its reference model once per rising edge. It compares every output at the next falling edge, so each result is checked in exactly the cycle it is due.

// File: rtl/rp_pkg.sv
package rp_pkg;
  localparam int unsigned RP_LANES_DEF   = 8;
  localparam int unsigned RP_CASCADE_DEF = 2;

  typedef struct packed {
    logic auto_eoi;
    logic rot_on_aeoi;
    logic nested_special;
    logic is_master;
  } rp_mode_t;
endpackage

// File: rtl/rp_req_latch.sv
module rp_req_latch #(
  parameter int unsigned LANES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] req_in,
  input  logic [LANES-1:0] trig_level,
  input  logic [LANES-1:0] clr_vec,
  output logic [LANES-1:0] irr_q
);
  logic [LANES-1:0] prev_q;
  logic [LANES-1:0] rise_vec;
  logic [LANES-1:0] irr_d;

  assign rise_vec = req_in & ~prev_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_comb begin
      if (trig_level[g]) irr_d[g] = req_in[g];
      else               irr_d[g] = (irr_q[g] & ~clr_vec[g]) | rise_vec[g];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      irr_q  <= '0;
    end else begin
      prev_q <= req_in;
      irr_q  <= irr_d;
    end
  end

  // R2
  lvl_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((irr_q & $past(trig_level)) == ($past(req_in) & $past(trig_level))));

  // R3
  edge_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(irr_q) & ~$past(trig_level) & ~$past(clr_vec)) & ~irr_q) == '0));

  // R3
  edge_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(rise_vec) & ~$past(trig_level)) & ~irr_q) == '0));
endmodule

// File: rtl/rp_resolver.sv
module rp_resolver #(
  parameter int unsigned LANES   = 8,
  parameter int unsigned CASCADE = 2
) (
  input  logic [LANES-1:0]         irr_q,
  input  logic [LANES-1:0]         mask,
  input  logic [LANES-1:0]         isr_q,
  input  logic [$clog2(LANES)-1:0] off_q,
  input  logic                     skip_cascade,
  output logic                     pending,
  output logic [$clog2(LANES)-1:0] win_idx
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam int unsigned PRI_W = IDX_W + 1;

  // Lowest rank k whose rotated position (k + off) holds a set bit; LANES if none.
  function automatic logic [PRI_W-1:0] rank_of(input logic [LANES-1:0] v,
                                              input logic [IDX_W-1:0] off);
    logic [IDX_W-1:0] pos;
    rank_of = PRI_W'(LANES);
    for (int k = LANES - 1; k >= 0; k--) begin
      pos = IDX_W'(k) + off;
      if (v[pos]) rank_of = PRI_W'(k);
    end
  endfunction

  function automatic logic [IDX_W-1:0] rank_to_idx(input logic [PRI_W-1:0] rank,
                                                   input logic [IDX_W-1:0] off);
    rank_to_idx = rank[IDX_W-1:0] + off;
  endfunction

  logic [LANES-1:0] cand_vec;
  logic [LANES-1:0] svc_vec;
  logic [PRI_W-1:0] cand_rank;
  logic [PRI_W-1:0] svc_rank;

  assign cand_vec = irr_q & ~mask;

  always_comb begin
    svc_vec = isr_q;
    if (skip_cascade) svc_vec[CASCADE] = 1'b0;
  end

  assign cand_rank = rank_of(cand_vec, off_q);
  assign svc_rank  = rank_of(svc_vec, off_q);
  assign pending   = cand_rank < svc_rank;
  assign win_idx   = rank_to_idx(cand_rank, off_q);
endmodule

// File: rtl/rp_service.sv
module rp_service #(
  parameter int unsigned LANES = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ack,
  input  logic                     pending,
  input  logic [$clog2(LANES)-1:0] win_idx,
  input  logic                     auto_eoi,
  input  logic                     rot_on_aeoi,
  output logic [LANES-1:0]         clr_vec,
  output logic [LANES-1:0]         isr_q,
  output logic [$clog2(LANES)-1:0] off_q,
  output logic                     ack_done,
  output logic                     ack_hit,
  output logic [$clog2(LANES)-1:0] ack_idx
);
  localparam int unsigned IDX_W = $clog2(LANES);
  localparam logic [IDX_W-1:0] SPURIOUS_IDX = IDX_W'(LANES - 1);

  logic             take;
  logic [LANES-1:0] take_hot;

  assign take     = ack & pending;
  assign take_hot = take ? (LANES'(1) << win_idx) : '0;
  assign clr_vec  = take_hot;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      isr_q    <= '0;
      off_q    <= '0;
      ack_done <= 1'b0;
      ack_hit  <= 1'b0;
      ack_idx  <= '0;
    end else begin
      ack_done <= ack;
      ack_hit  <= take;
      if (ack) ack_idx <= pending ? win_idx : SPURIOUS_IDX;
      if (!auto_eoi) isr_q <= isr_q | take_hot;
      if (take && auto_eoi && rot_on_aeoi) off_q <= win_idx + IDX_W'(1);
    end
  end

  // R9
  ack_mark_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !auto_eoi) |=> (((isr_q & $past(take_hot)) == $past(take_hot)) && ack_hit && ack_done));

  // R10
  aeoi_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (take && auto_eoi) |=> (isr_q == $past(isr_q)));

  // R10
  off_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(take && auto_eoi && rot_on_aeoi) |=> $stable(off_q));

  // R11
  spurious_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !pending) |=> (!ack_hit && ack_done && (ack_idx == SPURIOUS_IDX) && $stable(isr_q)));
endmodule

// File: rtl/rp_irq_core.sv
module rp_irq_core #(
  parameter int unsigned LANES   = rp_pkg::RP_LANES_DEF,
  parameter int unsigned CASCADE = rp_pkg::RP_CASCADE_DEF
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [LANES-1:0]         req_in,
  input  logic [LANES-1:0]         trig_level,
  input  logic [LANES-1:0]         mask,
  input  logic                     auto_eoi,
  input  logic                     rot_on_aeoi,
  input  logic                     nested_special,
  input  logic                     is_master,
  input  logic                     ack,
  output logic                     irq_out,
  output logic                     ack_done,
  output logic                     ack_hit,
  output logic [$clog2(LANES)-1:0] ack_idx,
  output logic [LANES-1:0]         irr_out,
  output logic [LANES-1:0]         isr_out
);
  localparam int unsigned IDX_W = $clog2(LANES);

  rp_pkg::rp_mode_t mode;
  logic [LANES-1:0] irr_q;
  logic [LANES-1:0] isr_q;
  logic [LANES-1:0] clr_vec;
  logic [IDX_W-1:0] off_q;
  logic [IDX_W-1:0] win_idx;
  logic             pending;
  logic             skip_cascade;
  logic             irq_q;

  assign mode = '{auto_eoi:       auto_eoi,
                  rot_on_aeoi:    rot_on_aeoi,
                  nested_special: nested_special,
                  is_master:      is_master};
  assign skip_cascade = mode.nested_special & mode.is_master;

  rp_req_latch #(.LANES(LANES)) u_latch (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_in     (req_in),
    .trig_level (trig_level),
    .clr_vec    (clr_vec),
    .irr_q      (irr_q)
  );

  rp_resolver #(.LANES(LANES), .CASCADE(CASCADE)) u_resolve (
    .irr_q        (irr_q),
    .mask         (mask),
    .isr_q        (isr_q),
    .off_q        (off_q),
    .skip_cascade (skip_cascade),
    .pending      (pending),
    .win_idx      (win_idx)
  );

  rp_service #(.LANES(LANES)) u_service (
    .clk         (clk),
    .rst_n       (rst_n),
    .ack         (ack),
    .pending     (pending),
    .win_idx     (win_idx),
    .auto_eoi    (mode.auto_eoi),
    .rot_on_aeoi (mode.rot_on_aeoi),
    .clr_vec     (clr_vec),
    .isr_q       (isr_q),
    .off_q       (off_q),
    .ack_done    (ack_done),
    .ack_hit     (ack_hit),
    .ack_idx     (ack_idx)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= pending;
  end

  assign irq_out = irq_q;
  assign irr_out = irr_q;
  assign isr_out = isr_q;

  // R8
  irq_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (irq_out == $past(pending)));

  // R5
  win_unmasked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending |-> (irr_q[win_idx] && !mask[win_idx]));

  // R6
  svc_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irr_q == '0) |-> !pending);
endmodule

// File: tb/rp_irq_core_tb.sv
`timescale 1ns/1ps
module rp_irq_core_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] req_in = '0, trig_level = '0, mask = '0;
  logic       auto_eoi = 1'b0, rot_on_aeoi = 1'b0, nested_special = 1'b0, is_master = 1'b0;
  logic       ack = 1'b0;
  logic       irq_out, ack_done, ack_hit;
  logic [2:0] ack_idx;
  logic [7:0] irr_out, isr_out;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // reference model state
  logic [7:0] m_irr, m_isr, m_prev;
  logic [2:0] m_off, m_idx;
  logic       m_irq, m_done, m_hit;

  always #4 clk = ~clk;

  rp_irq_core u_dut (
    .clk(clk), .rst_n(rst_n), .req_in(req_in), .trig_level(trig_level), .mask(mask),
    .auto_eoi(auto_eoi), .rot_on_aeoi(rot_on_aeoi), .nested_special(nested_special),
    .is_master(is_master), .ack(ack), .irq_out(irq_out), .ack_done(ack_done),
    .ack_hit(ack_hit), .ack_idx(ack_idx), .irr_out(irr_out), .isr_out(isr_out)
  );

  // circular distance of input i behind offset; best = smallest distance
  function automatic int best_dist(input logic [7:0] v, input logic [2:0] off);
    int best = 8;
    for (int i = 0; i < 8; i++) begin
      int d = (i + 8 - int'(off)) % 8;
      if (v[i] && d < best) best = d;
    end
    return best;
  endfunction

  task automatic chk(input string tag, input string what, input int got, input int exp);
    n_checks++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_irr = '0; m_isr = '0; m_prev = '0; m_off = '0; m_idx = '0;
    m_irq = 0; m_done = 0; m_hit = 0;
  endtask

  task automatic model_step();
    logic [7:0] cand, svc, nirr, nisr;
    int cr, sr, w;
    bit pend, take;
    cand = m_irr & ~mask;
    svc = m_isr;
    if (nested_special && is_master) svc[2] = 1'b0;
    cr = best_dist(cand, m_off);
    sr = best_dist(svc, m_off);
    pend = cr < sr;
    w = (cr + int'(m_off)) % 8;
    take = ack && pend;
    for (int i = 0; i < 8; i++) begin
      if (trig_level[i]) nirr[i] = req_in[i];
      else nirr[i] = (m_irr[i] && !(take && w == i)) || (req_in[i] && !m_prev[i]);
    end
    nisr = m_isr;
    if (take && !auto_eoi) nisr[w] = 1'b1;
    if (take && auto_eoi && rot_on_aeoi) m_off = 3'((w + 1) % 8);
    if (ack) m_idx = pend ? 3'(w) : 3'd7;
    m_done = ack; m_hit = take; m_irq = pend;
    m_irr = nirr; m_isr = nisr; m_prev = req_in;
  endtask

  task automatic compare_all();
    chk("R8", "irq_out", irq_out, m_irq);
    chk("R2/R3", "irr_out", irr_out, m_irr);
    chk("R9", "isr_out", isr_out, m_isr);
    chk("R9", "ack_done", ack_done, m_done);
    chk("R11", "ack_hit", ack_hit, m_hit);
    chk("R9", "ack_idx", ack_idx, m_idx);
  endtask

  task automatic cycle(input logic [7:0] r, input logic a);
    req_in = r; ack = a;
    model_step();
    @(negedge clk);
    compare_all();
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; req_in = '0; ack = 0;
    @(negedge clk);
    model_reset();
    chk("R1", "irr reset", irr_out, 0);
    chk("R1", "isr reset", isr_out, 0);
    chk("R1", "irq reset", irq_out, 0);
    chk("R1", "ack reset", {ack_done, ack_hit, ack_idx}, 0);
    rst_n = 1;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'h5EED_1234);

    // R2: level capture follows line, ack keeps it
    trig_level = 8'hFF; do_reset();
    cycle(8'h08, 0); cycle(8'h08, 0);
    chk("R8", "irq after level req", irq_out, 1);
    cycle(8'h08, 1);
    chk("R9", "ack idx level", ack_idx, 3);
    chk("R2", "level bit kept on ack", irr_out, 8'h08);
    cycle(8'h00, 0);
    chk("R2", "level bit cleared by low", irr_out, 8'h00);

    // R3 / R6: edge capture and strict in-service compare
    trig_level = 8'h00; do_reset();
    cycle(8'h20, 0); cycle(8'h00, 0); cycle(8'h00, 0);
    chk("R3", "edge bit held low", irr_out, 8'h20);
    cycle(8'h00, 1);
    chk("R3", "edge bit cleared on ack", irr_out, 8'h00);
    chk("R9", "isr set", isr_out, 8'h20);
    cycle(8'h20, 0); cycle(8'h20, 0);
    chk("R6", "equal rank blocked", irq_out, 0);

    // R5: masked request latched but not raised
    do_reset(); mask = 8'h10;
    cycle(8'h10, 0); cycle(8'h10, 0);
    chk("R5", "masked no irq", irq_out, 0);
    chk("R5", "masked still latched", irr_out, 8'h10);
    mask = 8'h00; cycle(8'h10, 0);
    chk("R5", "unmasked irq", irq_out, 1);

    // R4 / R10: rotation on auto end of interrupt
    do_reset(); auto_eoi = 1; rot_on_aeoi = 1;
    cycle(8'h81, 0); cycle(8'h00, 0); cycle(8'h00, 1);
    chk("R4", "offset 0 winner", ack_idx, 0);
    chk("R10", "no isr with auto eoi", isr_out, 0);
    cycle(8'h01, 0); cycle(8'h00, 1);
    chk("R4", "offset 1 winner", ack_idx, 7);
    cycle(8'h00, 1);
    chk("R10", "rotated back winner", ack_idx, 0);
    auto_eoi = 0; rot_on_aeoi = 0;

    // R7: special nested master ignores cascade in-service bit
    do_reset(); nested_special = 1; is_master = 1;
    cycle(8'h04, 0); cycle(8'h00, 1);
    chk("R7", "cascade in service", isr_out, 8'h04);
    cycle(8'h08, 0); cycle(8'h00, 0);
    chk("R7", "lower input passes", irq_out, 1);
    is_master = 0; cycle(8'h00, 0);
    chk("R7", "non-master blocked", irq_out, 0);
    nested_special = 0;

    // R11: spurious acknowledge
    do_reset(); cycle(8'h00, 1);
    chk("R11", "spurious idx", ack_idx, 7);
    chk("R11", "spurious hit", ack_hit, 0);
    chk("R11", "spurious isr", isr_out, 0);

    // random segments against the model
    for (int seg = 0; seg < 12; seg++) begin
      logic [7:0] r;
      trig_level = 8'($urandom); mask = 8'($urandom) & 8'($urandom);
      auto_eoi = 1'($urandom); rot_on_aeoi = 1'($urandom);
      nested_special = 1'($urandom); is_master = 1'($urandom);
      do_reset();
      r = '0;
      for (int c = 0; c < 200; c++) begin
        r = r ^ (8'($urandom) & 8'($urandom) & 8'($urandom));
        if (($urandom % 16) == 0) mask = 8'($urandom) & 8'($urandom);
        cycle(r, ($urandom % 4) == 0);
      end
    end

    finish_run();
  end
endmodule